// File: doc/BRIEF.md
# Eighth-Turn Twiddle Rotator

This block rotates one complex fixed-point sample per clock by 1, -j, e^{-jπ/4} or e^{-j3π/4}. These are the four rotations the last radix-2 pipeline stage of a power-of-two transform needs. A two-bit select picks the rotation for each sample. The block contains no general multiplier and no coefficient table. The 45-degree rotation forms the sum and the difference of the two components and scales both by a 1/√2 approximation. That approximation is built from shifts and three adders. The 135-degree rotation reuses that same scaling path and follows it with a quarter-turn made from multiplexers and a negation.

Each sample comes with a valid strobe, and the result appears one clock later with its own strobe. The outputs are one bit wider than the inputs. Every input value, including the full negative scale, therefore has a representable result. While no sample is offered, the output register keeps its last value.

Top module: `eighth_turn_rotator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0 and both output components are 0.
- R2: out_valid equals the value in_valid had on the previous clock edge.
- R3: Select code 2'b00 passes the sample unchanged: out_re = in_re and out_im = in_im, sign-extended to W+1 bits.
- R4: Select code 2'b01 multiplies by -j, exactly: out_re = in_im and out_im = -in_re.
- R5: Select code 2'b10 multiplies by e^{-jπ/4}: out_re ≈ k·(in_re+in_im) and out_im ≈ k·(in_im-in_re). Here k = 181/256 = 0.70703125, and each output is within one LSB.
- R6: Select code 2'b11 multiplies by e^{-j3π/4}: out_re ≈ k·(in_im-in_re) and out_im ≈ -k·(in_re+in_im), each within one LSB.
- R7: A clock edge with in_valid low leaves out_re and out_im unchanged.
- R8: Full-scale inputs, including both components at -2^(W-1), produce correct results in all four modes without wrap-around.
- R9: In the scaled modes (2'b10, 2'b11), a component whose exact value is zero (sum or difference of the input parts equal to zero) is output as exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| sel | input | 2 | Rotation select: bit 1 = 45-degree step, bit 0 = quarter-turn (-j) step |
| in_re | input | W | Real part of the sample, two's complement |
| in_im | input | W | Imaginary part of the sample, two's complement |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_re | output | W+1 | Real part of the rotated sample |
| out_im | output | W+1 | Imaginary part of the rotated sample |

## Verification
On every clock the assertions check four properties:
- the one-cycle strobe delay;
- the exact results of the pass-through and -j modes;
- that the outputs hold on idle edges;
- that a zero sum is output as an exact zero.

The accuracy of the two scaled rotations appears only in the bench's scenarios. There, a behavioural model computes the ideal value from the constant 181/256 and allows one LSB. The scenarios include random samples in every mode, full-scale corners and idle gaps. The bench's scenarios also cover the reset values and the extreme negative inputs.

// File: rtl/eighth_turn_rotator.sv
module eighth_turn_rotator #(
  parameter int W    = 16,
  parameter int FRAC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          sel,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  output logic signed [W:0]   out_re,
  output logic signed [W:0]   out_im
);
  localparam int OW = W + 1;
  localparam int IW = OW + FRAC + 2;

  // k = 1 + (1 + 1/4)(1/64 - 1/4) = 181/256, rounded once at the end
  function automatic logic signed [OW-1:0] halfroot(input logic signed [OW-1:0] x);
    logic signed [IW-1:0] xe, t, u, y, r;
    xe = $signed({{(IW-OW){x[OW-1]}}, x}) <<< FRAC;
    t  = xe + (xe >>> 2);
    u  = (t >>> 6) - (t >>> 2);
    y  = xe + u;
    r  = (y + (IW'(1) <<< (FRAC - 1))) >>> FRAC;
    return OW'(r);
  endfunction

  logic signed [OW-1:0] a_x, b_x, sum_ab, dif_ba;
  logic signed [OW-1:0] sc_re, sc_im, p_re, p_im, r_re, r_im;

  assign a_x    = {in_re[W-1], in_re};
  assign b_x    = {in_im[W-1], in_im};
  assign sum_ab = a_x + b_x;
  assign dif_ba = b_x - a_x;
  assign sc_re  = halfroot(sum_ab);
  assign sc_im  = halfroot(dif_ba);

  assign p_re = sel[1] ? sc_re : a_x;
  assign p_im = sel[1] ? sc_im : b_x;
  assign r_re = sel[0] ? p_im  : p_re;
  assign r_im = sel[0] ? -p_re : p_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= r_re;
        out_im <= r_im;
      end
    end
  end
endmodule

// File: rtl/eighth_turn_rotator_chk.sv
module eighth_turn_rotator_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          sel,
  input logic signed [W-1:0] in_re,
  input logic signed [W-1:0] in_im,
  input logic                out_valid,
  input logic signed [W:0]   out_re,
  input logic signed [W:0]   out_im
);
  logic live;
  logic signed [W:0] ea, eb, esum;
  assign ea   = {in_re[W-1], in_re};
  assign eb   = {in_im[W-1], in_im};
  assign esum = ea + eb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> out_valid == $past(in_valid));

  assert_pass_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(in_valid) && $past(sel) == 2'b00 |->
      out_re == $past(ea) && out_im == $past(eb));

  assert_negj_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(in_valid) && $past(sel) == 2'b01 |->
      out_re == $past(eb) && out_im == -$past(ea));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(in_valid) |-> $stable(out_re) && $stable(out_im));

  assert_zero_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(in_valid) && $past(sel) == 2'b10 && $past(esum) == 0 |->
      out_re == 0);
endmodule

bind eighth_turn_rotator eighth_turn_rotator_chk #(.W(W)) u_chk (.*);

// File: tb/tb_eighth_turn_rotator.sv
module tb_eighth_turn_rotator;
  localparam int  W  = 16;
  localparam time TP = 10;
  localparam real K  = 181.0 / 256.0;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] sel = 2'b00;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [W:0] out_re, out_im;

  int total = 0, bad = 0;
  real m_re = 0.0, m_im = 0.0, m_tol = 0.0;
  string m_tag = "R1";

  always #(TP/2) clk = ~clk;

  eighth_turn_rotator #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what, input real got, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0.4f exp=%0.4f", tag, what, got, exp);
    end
  endtask

  function automatic real absr(input real x);
    return x < 0.0 ? -x : x;
  endfunction

  task automatic step(input bit v, input logic [1:0] s, input int a, input int b, input string tag);
    real sm, df;
    @(negedge clk);
    in_valid = v; sel = s; in_re = W'(a); in_im = W'(b);
    @(posedge clk); #1;
    sm = real'(a + b); df = real'(b - a);
    if (v) begin
      m_tag = tag;
      case (s)
        2'b00: begin m_re = a;       m_im = b;        m_tol = 0.0; end
        2'b01: begin m_re = b;       m_im = -a;       m_tol = 0.0; end
        2'b10: begin m_re = K * sm;  m_im = K * df;   m_tol = 1.0; end
        default: begin m_re = K * df; m_im = -K * sm; m_tol = 1.0; end
      endcase
    end
    chk(out_valid == v, "R2", "out_valid", real'(out_valid), real'(v));
    chk(absr(real'(out_re) - m_re) <= m_tol, v ? m_tag : "R7", "out_re", real'(out_re), m_re);
    chk(absr(real'(out_im) - m_im) <= m_tol, v ? m_tag : "R7", "out_im", real'(out_im), m_im);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string mtag [4] = '{"R3", "R4", "R5", "R6"};
    int mn, mx;
    mn = -(1 <<< (W-1)); mx = (1 <<< (W-1)) - 1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && out_re == 0 && out_im == 0, "R1", "reset state", real'(out_re), 0.0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0 && out_re == 0 && out_im == 0, "R1", "after release", real'(out_re), 0.0);

    step(1, 2'b00, 1234, -567, "R3");
    step(1, 2'b01, 1234, -567, "R4");
    step(1, 2'b10, 1000, 1000, "R5");
    step(1, 2'b11, 1000, 1000, "R6");
    step(0, 2'b10, 99, 99, "R7");
    step(0, 2'b01, -5, 7, "R7");

    for (int s = 0; s < 4; s++) begin
      step(1, 2'(s), mn, mn, "R8");
      step(1, 2'(s), mx, mx, "R8");
      step(1, 2'(s), mn, mx, "R8");
      step(1, 2'(s), mx, mn, "R8");
    end
    step(1, 2'b01, mn, 0, "R4");
    chk(out_im == (1 <<< (W-1)), "R4", "negate full scale", real'(out_im), real'(1 <<< (W-1)));

    step(1, 2'b10, 777, -777, "R9");
    chk(out_re == 0, "R9", "zero sum mode 10", real'(out_re), 0.0);
    step(1, 2'b11, -321, -321, "R9");
    chk(out_re == 0, "R9", "zero diff mode 11", real'(out_re), 0.0);

    for (int i = 0; i < 2000; i++) begin
      int a, b, s;
      a = int'($urandom) >>> (32 - W);
      b = int'($urandom) >>> (32 - W);
      s = int'($urandom_range(0, 3));
      step(($urandom_range(0, 4) != 0), 2'(s), a, b, mtag[s]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule